// File: doc/BRIEF.md
# Mode Register and Burst Column Sequencer

This block sits on the command side of a double-data-rate memory device model. It watches the command strobes for register-write commands and keeps two small configuration registers from them. The main register holds burst length, burst ordering, read latency and a one-shot DLL reset request. The extended register holds the DLL disable bit and the output driver strength. Writes that carry a reserved or illegal encoding are refused with an error pulse, and the old settings stay in place.

For every read or write column command, the block plays out the column addresses of the burst, one address per clock. Each clock stands for a pair of data words, so the address given is the column of the first word of the pair. Sequential bursts wrap inside the aligned block of the burst length. Interleaved bursts XOR the start offset with the word index. A full-page burst walks all 256 columns and keeps going until another column command or a precharge stops it.

The address stream has no back-pressure. The memory timing fixes one address per clock, so there is no ready input, and `burst_active` acts as the valid for `col_addr`. All other pins are plain levels or one-cycle pulses.

Top module: `mode_burst_ctl`

## Requirements
- R1: After reset there is no burst, `mode_busy`, `mode_err` and `dll_rst` are low, and the settings are burst length 2 (`cfg_len`=0), sequential, latency code 3, DLL enabled and drive code 00.
- R2: A register write is chip select, row strobe, column strobe and write enable all low together. `ba[0]`=0 writes the main register and `ba[0]`=1 writes the extended register. In the main register, `a[2:0]` is the length code (001→2, 010→4, 011→8, 111→full page, shown on `cfg_len` as 0,1,2,3), `a[3]` is the ordering (1 interleaved) and `a[6:4]` is the latency. The new settings show on the next clock.
- R3: A main-register write is refused when the length code is 000, 100, 101 or 110, when the latency code is not 011, when `a[7]` is set, when any of `a[11:9]` is set, when `ba[1]` is set, or when interleaved is asked together with full page. A refused write pulses `mode_err` for one clock and changes no setting.
- R4: In the extended register, `a[0]`=1 disables the DLL and `cfg_drive`={`a[6]`,`a[1]`} (00 normal, 01 weak, 11 matched). Code 10 is refused, and so is any set bit among `a[5:2]`, `a[11:7]` or `ba[1]`. A refused write pulses `mode_err` and changes no setting.
- R5: Every register write that is taken holds `mode_busy` high for the next 2 clocks. Any command that arrives while `mode_busy` is high is ignored.
- R6: A column command is chip select low, row strobe high and column strobe low. From the next clock, `burst_active` is high for length/2 clocks, with `a[7:0]` as the start column and `auto_pre` reflecting `a[8]` for the whole burst.
- R7: With sequential order, clock i gives base | ((start+2i) mod L), where L is the burst length and base is the start with its low log2(L) bits cleared.
- R8: With interleaved order, clock i gives start XOR 2i.
- R9: A full-page burst gives (start+2i) mod 256 and runs until a new column command or a precharge arrives. A precharge (chip select low, row strobe low, column strobe high, write enable low) ends any burst on the next clock.
- R10: A full-page column command with an odd start column is refused. It pulses `mode_err` and starts no burst.
- R11: A column command during an active burst restarts the sequence from its own start column.
- R12: A register write issued while a burst is active is ignored. It causes no busy, no error and no change to the settings.
- R13: A main-register write that is taken with `a[8]`=1 pulses `dll_rst` for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank bits; bit 0 selects the register |
| a | input | 12 | Address bus |
| col_addr | output | 8 | Current burst column (0 when idle) |
| burst_active | output | 1 | Valid for col_addr |
| auto_pre | output | 1 | Auto-precharge request of current burst |
| mode_busy | output | 1 | Register write completing; commands ignored |
| mode_err | output | 1 | One-clock pulse on a refused command |
| dll_rst | output | 1 | One-clock DLL reset pulse |
| cfg_len | output | 2 | Length: 0=2, 1=4, 2=8, 3=full page |
| cfg_interleave | output | 1 | Interleaved ordering |
| cfg_cas_lat | output | 3 | Latency code |
| cfg_dll_off | output | 1 | DLL disabled |
| cfg_drive | output | 2 | Driver strength code |

## Verification
The properties assume that the settings do not change during a burst. This holds because register writes are ignored while a burst runs. They also assume that precharge and column commands never arrive in the same clock, which the one-hot decode guarantees. The stepping checks look only at clocks whose previous clock carried no column command. The stimulus drives one command per clock at the falling edge and places NOP clocks after each register write. It never asks for a full-page start that could be mistaken for a restart, so each expected address sequence is known in advance.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [1:0] {LEN_2 = 2'd0, LEN_4 = 2'd1, LEN_8 = 2'd2, LEN_FULL = 2'd3} len_sel_e;

  typedef enum logic [1:0] {CMD_NONE, CMD_MODE, CMD_COL, CMD_PRE} cmd_e;

  typedef struct packed {
    len_sel_e    len;
    logic        ilv;
    logic [2:0]  cl;
    logic        dll_off;
    logic [1:0]  drive;
  } cfg_t;

  localparam logic [2:0] CL_ONLY   = 3'b011;
  localparam cfg_t       CFG_RESET = '{len: LEN_2, ilv: 1'b0, cl: CL_ONLY,
                                       dll_off: 1'b0, drive: 2'b00};
endpackage

// File: rtl/mbc_cmd_decode.sv
module mbc_cmd_decode
  import mbc_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:         cmd = CMD_MODE;
        3'b100, 3'b101: cmd = CMD_COL;
        3'b010:         cmd = CMD_PRE;
        default:        cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mbc_mode_regs.sv
module mbc_mode_regs
  import mbc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] a,
  output cfg_t              cfg,
  output logic              busy,
  output logic              reject,
  output logic              dll_rst
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             len_ok, mr_ok, emr_ok;
  len_sel_e         len_dec;

  always_comb begin
    len_ok  = 1'b1;
    len_dec = LEN_2;
    case (a[2:0])
      3'b001:  len_dec = LEN_2;
      3'b010:  len_dec = LEN_4;
      3'b011:  len_dec = LEN_8;
      3'b111:  len_dec = LEN_FULL;
      default: len_ok  = 1'b0;
    endcase
  end

  assign mr_ok  = len_ok && (a[6:4] == CL_ONLY) && !a[7] && (a[ADDR_W-1:9] == '0)
                  && !ba[1] && !(a[3] && len_dec == LEN_FULL);
  assign emr_ok = (a[5:2] == 4'b0) && (a[ADDR_W-1:7] == '0) && !ba[1]
                  && !(a[6] && !a[1]);

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= CFG_RESET;
      cnt     <= '0;
      reject  <= 1'b0;
      dll_rst <= 1'b0;
    end else begin
      reject  <= 1'b0;
      dll_rst <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (wr_en) begin
        cnt <= CNT_W'(BUSY_CYC);
        if (ba[0]) begin
          if (emr_ok) begin
            cfg.dll_off <= a[0];
            cfg.drive   <= {a[6], a[1]};
          end else begin
            reject <= 1'b1;
          end
        end else if (mr_ok) begin
          cfg.len <= len_dec;
          cfg.ilv <= a[3];
          cfg.cl  <= a[6:4];
          dll_rst <= a[8];
        end else begin
          reject <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mbc_burst_seq.sv
module mbc_burst_seq
  import mbc_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] col_in,
  input  logic             ap_in,
  input  len_sel_e         len,
  input  logic             ilv,
  output logic             active,
  output logic [COL_W-1:0] col_addr,
  output logic             auto_pre,
  output logic             reject
);
  logic [COL_W-1:0] base, mask, step, half, k_next;
  logic [COL_W-2:0] k;
  logic             ap, start_ok;

  always_comb begin
    case (len)
      LEN_2:   begin mask = COL_W'(1); half = COL_W'(1); end
      LEN_4:   begin mask = COL_W'(3); half = COL_W'(2); end
      LEN_8:   begin mask = COL_W'(7); half = COL_W'(4); end
      default: begin mask = '1;        half = '0;        end
    endcase
  end

  assign step     = {k, 1'b0};
  assign k_next   = {1'b0, k} + 1'b1;
  assign start_ok = start && !(len == LEN_FULL && col_in[0]);
  assign auto_pre = active && ap;

  always_comb begin
    if (!active)  col_addr = '0;
    else if (ilv) col_addr = base ^ step;
    else          col_addr = (base & ~mask) | ((base + step) & mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      k      <= '0;
      ap     <= 1'b0;
      reject <= 1'b0;
    end else begin
      reject <= start && !start_ok;
      if (start_ok) begin
        active <= 1'b1;
        base   <= col_in;
        k      <= '0;
        ap     <= ap_in;
      end else if (stop) begin
        active <= 1'b0;
      end else if (active) begin
        k <= k_next[COL_W-2:0];
        if (len != LEN_FULL && k_next == half) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mode_burst_ctl.sv
module mode_burst_ctl
  import mbc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int COL_W    = 8,
  parameter int BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] a,
  output logic [COL_W-1:0]  col_addr,
  output logic              burst_active,
  output logic              auto_pre,
  output logic              mode_busy,
  output logic              mode_err,
  output logic              dll_rst,
  output logic [1:0]        cfg_len,
  output logic              cfg_interleave,
  output logic [2:0]        cfg_cas_lat,
  output logic              cfg_dll_off,
  output logic [1:0]        cfg_drive
);
  cmd_e cmd;
  cfg_t cfg;
  logic reg_rej, col_rej;

  mbc_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  mbc_mode_regs #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cmd == CMD_MODE && !mode_busy && !burst_active),
    .ba(ba), .a(a), .cfg(cfg), .busy(mode_busy),
    .reject(reg_rej), .dll_rst(dll_rst)
  );

  mbc_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(cmd == CMD_COL && !mode_busy),
    .stop(cmd == CMD_PRE && !mode_busy),
    .col_in(a[COL_W-1:0]), .ap_in(a[COL_W]),
    .len(cfg.len), .ilv(cfg.ilv),
    .active(burst_active), .col_addr(col_addr),
    .auto_pre(auto_pre), .reject(col_rej)
  );

  assign mode_err       = reg_rej || col_rej;
  assign cfg_len        = cfg.len;
  assign cfg_interleave = cfg.ilv;
  assign cfg_cas_lat    = cfg.cl;
  assign cfg_dll_off    = cfg.dll_off;
  assign cfg_drive      = cfg.drive;
endmodule

// File: rtl/mode_burst_ctl_chk.sv
module mode_burst_ctl_chk #(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic [COL_W-1:0]  col_addr,
  input logic              burst_active,
  input logic              auto_pre,
  input logic              mode_busy,
  input logic              mode_err,
  input logic              dll_rst,
  input logic [1:0]        cfg_len,
  input logic              cfg_interleave,
  input logic [2:0]        cfg_cas_lat,
  input logic              cfg_dll_off,
  input logic [1:0]        cfg_drive
);
  p_busy_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_busy) |=> mode_busy);

  p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_busy && $past(mode_busy)) |=> !mode_busy);

  p_busy_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_busy |-> !burst_active);

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (cfg_len == $past(cfg_len) && cfg_interleave == $past(cfg_interleave)
                  && cfg_cas_lat == $past(cfg_cas_lat) && cfg_dll_off == $past(cfg_dll_off)
                  && cfg_drive == $past(cfg_drive)));

  p_full_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && $past(burst_active) && cfg_len == 2'd3
     && $past(cs_n || cas_n || !ras_n)) |-> col_addr == COL_W'($past(col_addr) + 2));

  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && $past(burst_active) && cfg_len != 2'd3
     && $past(cs_n || cas_n || !ras_n)) |-> col_addr[COL_W-1:3] == $past(col_addr[COL_W-1:3]));

  p_dll_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    dll_rst |=> !dll_rst);

  p_ap_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> burst_active);
endmodule

bind mode_burst_ctl mode_burst_ctl_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_chk (.*);

// File: tb/mode_burst_ctl_test.sv
module mode_burst_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'b00;
  logic [11:0] a = '0;
  logic [7:0]  col_addr;
  logic        burst_active, auto_pre, mode_busy, mode_err, dll_rst;
  logic [1:0]  cfg_len, cfg_drive;
  logic        cfg_interleave, cfg_dll_off;
  logic [2:0]  cfg_cas_lat;

  int errors = 0;
  int checks = 0;
  logic [7:0] expq[$];

  always #2.5 clk = ~clk;

  mode_burst_ctl uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every valid column address must match the next queued expectation.
  always @(negedge clk) begin
    if (rst_n && burst_active) begin
      if (expq.size() == 0) chk(1'b0, "R6 unexpected address", col_addr, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(col_addr == e, "R7/R8/R9 column order", col_addr, e);
      end
    end
  end

  task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic [11:0] ad);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    a  = ad;
  endtask

  task automatic nop();
    drive(4'b1111, 2'b00, 12'h000);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int bl, input bit il, input int i);
    logic [7:0] m;
    if (bl == 256) return 8'(s + 2 * i);
    m = 8'(bl - 1);
    if (il) return s ^ 8'(2 * i);
    return (s & ~m) | (8'(s + 2 * i) & m);
  endfunction

  // Register write; returns at the first falling edge after the command edge.
  task automatic mode_wr(input logic [1:0] b, input logic [11:0] ad);
    drive(4'b0000, b, ad);
    @(negedge clk);
    nop();
  endtask

  // Column command; queues n expected addresses and returns one falling edge later.
  task automatic col(input logic [8:0] ad, input int bl, input bit il, input int n);
    for (int i = 0; i < n; i++) expq.push_back(exp_col(ad[7:0], bl, il, i));
    drive(4'b0101, 2'b00, {3'b000, ad});
    @(negedge clk);
    nop();
  endtask

  task automatic drained(input string tag);
    chk(expq.size() == 0, tag, expq.size(), 0);
    chk(!burst_active, tag, burst_active, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!burst_active && !mode_busy && !mode_err && !dll_rst, "R1 idle flags", 0, 0);
    chk(cfg_len == 2'd0 && !cfg_interleave && cfg_cas_lat == 3'd3, "R1 mode defaults", cfg_len, 0);
    chk(!cfg_dll_off && cfg_drive == 2'b00, "R1 ext defaults", cfg_drive, 0);

    // R2 main register write: BL4 sequential latency 3
    mode_wr(2'b00, 12'h032);
    chk(cfg_len == 2'd1 && !cfg_interleave && cfg_cas_lat == 3'd3, "R2 settings", cfg_len, 1);
    chk(mode_busy && !mode_err, "R5 busy first clock", mode_busy, 1);
    @(negedge clk);
    chk(mode_busy, "R5 busy second clock", mode_busy, 1);
    @(negedge clk);
    chk(!mode_busy, "R5 busy released", mode_busy, 0);

    // R5 commands during busy are ignored
    mode_wr(2'b00, 12'h032);
    drive(4'b0101, 2'b00, 12'h010);
    @(negedge clk);
    drive(4'b0101, 2'b00, 12'h020);
    @(negedge clk);
    nop();
    chk(!burst_active, "R5 column ignored", burst_active, 0);
    @(negedge clk);
    chk(!burst_active, "R5 column ignored late", burst_active, 0);

    // R6/R7 sequential BL4 from 5 -> 05,07
    col(9'h005, 4, 1'b0, 2);
    idle(3);
    drained("R6 BL4 length");

    // R6 auto precharge flag
    col(9'h104, 4, 1'b0, 2);
    chk(auto_pre, "R6 auto_pre high", auto_pre, 1);
    idle(3);
    chk(!auto_pre, "R6 auto_pre cleared", auto_pre, 0);
    drained("R6 BL4 with ap");

    // R8 interleaved BL8 from 0x13 -> 13,11,17,15
    mode_wr(2'b00, 12'h03B);
    idle(2);
    chk(cfg_interleave && cfg_len == 2'd2, "R2 interleave BL8", cfg_len, 2);
    col(9'h013, 8, 1'b1, 4);
    idle(5);
    drained("R8 BL8 length");

    // R7 sequential BL8 from 0x1E -> 1E,18,1A,1C
    mode_wr(2'b00, 12'h033);
    idle(2);
    col(9'h01E, 8, 1'b0, 4);
    idle(5);
    drained("R7 BL8 length");

    // R11 restart mid-burst
    col(9'h000, 8, 1'b0, 2);
    @(negedge clk);
    col(9'h040, 8, 1'b0, 4);
    idle(5);
    drained("R11 restart");

    // R12 register write during a burst is ignored
    col(9'h020, 8, 1'b0, 4);
    drive(4'b0000, 2'b00, 12'h032);
    @(negedge clk);
    nop();
    chk(!mode_busy && !mode_err, "R12 no busy or error", mode_busy, 0);
    chk(cfg_len == 2'd2, "R12 settings kept", cfg_len, 2);
    idle(4);
    drained("R12 burst completed");

    // R13 DLL reset pulse
    mode_wr(2'b00, 12'h133);
    chk(dll_rst, "R13 pulse", dll_rst, 1);
    @(negedge clk);
    chk(!dll_rst, "R13 pulse ends", dll_rst, 0);
    @(negedge clk);

    // R9 full page from 0xFC wraps, precharge ends it
    mode_wr(2'b00, 12'h037);
    idle(2);
    chk(cfg_len == 2'd3, "R2 full page", cfg_len, 3);
    col(9'h0FC, 256, 1'b0, 5);
    idle(4);
    drive(4'b0010, 2'b00, 12'h000);
    @(negedge clk);
    nop();
    drained("R9 precharge stop");

    // R10 odd full-page start rejected
    col(9'h0FD, 256, 1'b0, 0);
    chk(mode_err && !burst_active, "R10 odd start", mode_err, 1);
    @(negedge clk);
    chk(!mode_err && !burst_active, "R10 no burst", burst_active, 0);

    // R3 interleave with full page refused
    mode_wr(2'b00, 12'h03F);
    chk(mode_err && cfg_len == 2'd3 && !cfg_interleave, "R3 ilv full", cfg_len, 3);
    idle(2);
    // R3 reserved length code
    mode_wr(2'b00, 12'h034);
    chk(mode_err && cfg_len == 2'd3, "R3 reserved length", cfg_len, 3);
    idle(2);
    // R3 bad latency code
    mode_wr(2'b00, 12'h022);
    chk(mode_err && cfg_cas_lat == 3'd3, "R3 latency", cfg_cas_lat, 3);
    idle(2);
    // R3 test-mode bit set
    mode_wr(2'b00, 12'h0B2);
    chk(mode_err && cfg_len == 2'd3, "R3 a7 set", cfg_len, 3);
    idle(2);

    // R4 extended register
    mode_wr(2'b01, 12'h003);
    chk(!mode_err && cfg_dll_off && cfg_drive == 2'b01, "R4 dll off weak", cfg_drive, 1);
    idle(2);
    mode_wr(2'b01, 12'h041);
    chk(mode_err && cfg_dll_off && cfg_drive == 2'b01, "R4 code 10 refused", cfg_drive, 1);
    idle(2);
    mode_wr(2'b01, 12'h00B);
    chk(mode_err && cfg_drive == 2'b01, "R4 a3 refused", cfg_drive, 1);
    idle(2);
    mode_wr(2'b01, 12'h042);
    chk(!mode_err && !cfg_dll_off && cfg_drive == 2'b11, "R4 matched", cfg_drive, 3);
    chk(cfg_len == 2'd3, "R4 main register untouched", cfg_len, 3);
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule